// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block checks bus accesses against a table of programmable address regions. Each region has an inclusive page-aligned address window, a set of access-right bits and a valid flag. Several bus slave ports are checked in the same cycle against the same table. Each access carries an address, a master number, an access kind (read, write or execute) and a privilege flag. The registered verdict appears one cycle after the request. When checking is enabled, an access that no valid region permits gets a protection error.

A word-addressed configuration port programs the regions and the global enable. It also reads them back. The hardware keeps each region's valid flag coherent. Any change to a region's window or rights takes the region out of service until its final word is written. A second, alternate address for the rights word lets software change rights on a live region without taking it out of service. Each port keeps a fault record that holds the first denied access until software clears it.

Top module: `mpc_region_guard`

## Requirements
- R1: After reset the global enable reads 0, every region's valid flag reads 0, no response is pending and every fault record is empty.
- R2: While the global enable (control register bit 0) is 0, every access is answered without error, whatever its address, master or kind.
- R3: A response flag rises on a port exactly one cycle after a request on that port. An error flag is never raised without the response flag.
- R4: A region covers the pages from its start page to its end page inclusive, with 32-byte pages. Address bits 4:0 are ignored on write. They read back as zeros in the start word and as ones in the end word.
- R5: Kind encoding is 0 read, 1 write, 2 execute and 3 reserved. Rights bits: 0/1/2 are privileged read/write/execute for master 0; 3/4/5 are unprivileged read/write/execute for master 0; 6/7 are read/write for master 1; 8/9 are read/write for master 2. Execute by masters 1 and 2, kind 3, and master numbers above 2 are never permitted.
- R6: When an access falls in several valid regions, it is permitted if any one of them grants the needed right.
- R7: While enabled, an access that hits no valid region, or lacks the right in every region it hits, gets an error.
- R8: Writing region word 0 (start), 1 (end) or 2 (rights) clears that region's valid flag. Writing word 3 sets it. Word 3 reads back the valid flag in bit 0.
- R9: A write to a region's alternate rights address changes only its rights and leaves every valid flag unchanged.
- R10: The ports are checked independently in the same cycle. A request on one port does not affect the verdict on another.
- R11: On an error, an empty fault record captures the address, master and kind. It holds them until the port's clear input is raised. An error in the same cycle as a clear is captured.
- R12: Config address = {space[1:0], region[3:0], word[1:0]}. Space 0 holds the region words, space 1 the alternate rights word, and space 2 the control register. Reads return the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| acc_req | input | 2 | Access request, one per port |
| acc_addr | input | 2x32 | Access byte address per port |
| acc_mid | input | 2x2 | Master number per port |
| acc_kind | input | 2x2 | Access kind per port |
| acc_sup | input | 2 | Privileged access flag per port |
| rsp_vld | output | 2 | Verdict valid, one cycle after request |
| rsp_err | output | 2 | Protection error verdict |
| flt_clr | input | 2 | Fault record clear per port |
| flt_vld | output | 2 | Fault record holds an entry |
| flt_addr | output | 2x32 | Captured fault address |
| flt_mid | output | 2x2 | Captured fault master |
| flt_kind | output | 2x2 | Captured fault kind |

## Verification
The assertions check on every cycle that the response follows the request by one cycle and that no error is raised while checking is off. They also check that an error always leaves a filled fault record, that a filled record stays frozen until cleared, and how valid flags react to each kind of config write. Only the bench's scenarios can show that the verdict itself is right. That covers inclusive boundary pages, the rights bit chosen for each master and privilege, granting across overlapping regions, and rights changed through the alternate address. These are compared against a reference model, using directed edge cases and seeded random accesses over randomly programmed, overlapping windows.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
   typedef enum logic [1:0] {
      ACC_RD  = 2'd0,
      ACC_WR  = 2'd1,
      ACC_EX  = 2'd2,
      ACC_RSV = 2'd3
   } acc_kind_e;

   // config address spaces
   localparam logic [1:0] SP_DESC = 2'd0;
   localparam logic [1:0] SP_ALT  = 2'd1;
   localparam logic [1:0] SP_CTRL = 2'd2;

   // region word numbers
   localparam logic [1:0] WD_START = 2'd0;
   localparam logic [1:0] WD_END   = 2'd1;
   localparam logic [1:0] WD_ACC   = 2'd2;
   localparam logic [1:0] WD_VALID = 2'd3;

   // rights bits owned by master 0 (privileged rwx, unprivileged rwx)
   localparam int CORE_BITS = 6;
   localparam int USER_OFS  = 3;

   function automatic int acc_width(input int n_masters);
      return CORE_BITS + 2 * (n_masters - 1);
   endfunction
endpackage

// File: rtl/mpc_desc_bank.sv
module mpc_desc_bank
   import mpc_pkg::*;
#(
   parameter int NUM_REGIONS = 16,
   parameter int ADDR_W      = 32,
   parameter int GRAN_LSB    = 5,
   parameter int ACC_W       = 10,
   parameter int DATA_W      = 32,
   localparam int RA_W       = ADDR_W - GRAN_LSB,
   localparam int RI_W       = $clog2(NUM_REGIONS),
   localparam int CFG_AW     = RI_W + 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [CFG_AW-1:0]                 cfg_addr,
   input  logic [DATA_W-1:0]                 cfg_wdata,
   output logic [DATA_W-1:0]                 cfg_rdata,
   output logic                              glb_en,
   output logic [NUM_REGIONS-1:0][RA_W-1:0]  rgn_lo,
   output logic [NUM_REGIONS-1:0][RA_W-1:0]  rgn_hi,
   output logic [NUM_REGIONS-1:0][ACC_W-1:0] rgn_acc,
   output logic [NUM_REGIONS-1:0]            rgn_vld
);
   logic [1:0]      sp;
   logic [RI_W-1:0] idx;
   logic [1:0]      wd;

   assign sp  = cfg_addr[CFG_AW-1 -: 2];
   assign idx = cfg_addr[RI_W+1:2];
   assign wd  = cfg_addr[1:0];

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
      logic sel_r, wr_desc, wr_alt;
      assign sel_r   = (idx == RI_W'(r));
      assign wr_desc = cfg_we && (sp == SP_DESC) && sel_r;
      assign wr_alt  = cfg_we && (sp == SP_ALT) && sel_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rgn_lo[r]  <= '0;
            rgn_hi[r]  <= '0;
            rgn_acc[r] <= '0;
            rgn_vld[r] <= 1'b0;
         end else begin
            if (wr_desc && wd == WD_START) rgn_lo[r] <= cfg_wdata[ADDR_W-1:GRAN_LSB];
            if (wr_desc && wd == WD_END)   rgn_hi[r] <= cfg_wdata[ADDR_W-1:GRAN_LSB];
            if ((wr_desc && wd == WD_ACC) || wr_alt) rgn_acc[r] <= cfg_wdata[ACC_W-1:0];
            // any edit of window or rights retires the region; the last word arms it
            if (wr_desc) rgn_vld[r] <= (wd == WD_VALID);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        glb_en <= 1'b0;
      else if (cfg_we && sp == SP_CTRL)  glb_en <= cfg_wdata[0];
   end

   always_comb begin
      cfg_rdata = '0;
      case (sp)
         SP_DESC: begin
            case (wd)
               WD_START: cfg_rdata = DATA_W'({rgn_lo[idx], {GRAN_LSB{1'b0}}});
               WD_END:   cfg_rdata = DATA_W'({rgn_hi[idx], {GRAN_LSB{1'b1}}});
               WD_ACC:   cfg_rdata = DATA_W'(rgn_acc[idx]);
               default:  cfg_rdata = DATA_W'(rgn_vld[idx]);
            endcase
         end
         SP_ALT:  cfg_rdata = DATA_W'(rgn_acc[idx]);
         SP_CTRL: cfg_rdata = DATA_W'(glb_en);
         default: cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mpc_port_check.sv
module mpc_port_check
   import mpc_pkg::*;
#(
   parameter int NUM_REGIONS = 16,
   parameter int ADDR_W      = 32,
   parameter int GRAN_LSB    = 5,
   parameter int NUM_MASTERS = 3,
   parameter int ACC_W       = 10,
   parameter int MID_W       = 2,
   localparam int RA_W       = ADDR_W - GRAN_LSB
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              glb_en,
   input  logic [NUM_REGIONS-1:0][RA_W-1:0]  rgn_lo,
   input  logic [NUM_REGIONS-1:0][RA_W-1:0]  rgn_hi,
   input  logic [NUM_REGIONS-1:0][ACC_W-1:0] rgn_acc,
   input  logic [NUM_REGIONS-1:0]            rgn_vld,
   input  logic                              req,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [MID_W-1:0]                  mid,
   input  logic [1:0]                        kind,
   input  logic                              sup,
   output logic                              deny_now,
   output logic                              rsp_vld,
   output logic                              rsp_err
);
   logic [ACC_W-1:0]       need;
   logic [NUM_REGIONS-1:0] grant;
   logic [RA_W-1:0]        page;
   acc_kind_e              kind_e;

   assign page   = addr[ADDR_W-1:GRAN_LSB];
   assign kind_e = acc_kind_e'(kind);

   // one-hot mask of the single rights bit this access needs (zero if none can)
   always_comb begin
      int want;
      want = -1;
      if (mid == '0) begin
         if (kind_e != ACC_RSV) want = (sup ? 0 : USER_OFS) + int'(kind);
      end else if (int'(mid) < NUM_MASTERS) begin
         if (kind_e == ACC_RD)      want = CORE_BITS + 2 * (int'(mid) - 1);
         else if (kind_e == ACC_WR) want = CORE_BITS + 2 * (int'(mid) - 1) + 1;
      end
      for (int b = 0; b < ACC_W; b++) need[b] = (want == b);
   end

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
      logic in_win;
      assign in_win   = (page >= rgn_lo[r]) && (page <= rgn_hi[r]);
      assign grant[r] = rgn_vld[r] && in_win && |(rgn_acc[r] & need);
   end

   assign deny_now = req && glb_en && !(|grant);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld <= 1'b0;
         rsp_err <= 1'b0;
      end else begin
         rsp_vld <= req;
         rsp_err <= deny_now;
      end
   end
endmodule

// File: rtl/mpc_fault_rec.sv
module mpc_fault_rec #(
   parameter int ADDR_W     = 32,
   parameter int MID_W      = 2,
   parameter bit KEEP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              clr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [MID_W-1:0]  mid,
   input  logic [1:0]        kind,
   output logic              flt_vld,
   output logic [ADDR_W-1:0] flt_addr,
   output logic [MID_W-1:0]  flt_mid,
   output logic [1:0]        flt_kind
);
   logic take;

   if (KEEP_FIRST) begin : g_first
      assign take = cap && (!flt_vld || clr);
   end else begin : g_last
      assign take = cap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_vld  <= 1'b0;
         flt_addr <= '0;
         flt_mid  <= '0;
         flt_kind <= '0;
      end else if (take) begin
         flt_vld  <= 1'b1;
         flt_addr <= addr;
         flt_mid  <= mid;
         flt_kind <= kind;
      end else if (clr) begin
         flt_vld  <= 1'b0;
      end
   end
endmodule

// File: rtl/mpc_region_guard.sv
module mpc_region_guard
   import mpc_pkg::*;
#(
   parameter int NUM_REGIONS = 16,
   parameter int NUM_PORTS   = 2,
   parameter int ADDR_W      = 32,
   parameter int GRAN_LSB    = 5,
   parameter int NUM_MASTERS = 3,
   parameter int DATA_W      = 32,
   parameter bit KEEP_FIRST  = 1'b1,
   localparam int MID_W      = $clog2(NUM_MASTERS),
   localparam int ACC_W      = acc_width(NUM_MASTERS),
   localparam int RA_W       = ADDR_W - GRAN_LSB,
   localparam int RI_W       = $clog2(NUM_REGIONS),
   localparam int CFG_AW     = RI_W + 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [CFG_AW-1:0]                 cfg_addr,
   input  logic [DATA_W-1:0]                 cfg_wdata,
   output logic [DATA_W-1:0]                 cfg_rdata,
   input  logic [NUM_PORTS-1:0]              acc_req,
   input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  acc_addr,
   input  logic [NUM_PORTS-1:0][MID_W-1:0]   acc_mid,
   input  logic [NUM_PORTS-1:0][1:0]         acc_kind,
   input  logic [NUM_PORTS-1:0]              acc_sup,
   output logic [NUM_PORTS-1:0]              rsp_vld,
   output logic [NUM_PORTS-1:0]              rsp_err,
   input  logic [NUM_PORTS-1:0]              flt_clr,
   output logic [NUM_PORTS-1:0]              flt_vld,
   output logic [NUM_PORTS-1:0][ADDR_W-1:0]  flt_addr,
   output logic [NUM_PORTS-1:0][MID_W-1:0]   flt_mid,
   output logic [NUM_PORTS-1:0][1:0]         flt_kind
);
   // elaboration-time parameter checks
   if (NUM_REGIONS < 2 || NUM_REGIONS > 64 || (NUM_REGIONS & (NUM_REGIONS - 1)) != 0) begin : g_bad_rgn
      $error("NUM_REGIONS must be a power of two from 2 to 64");
   end
   if (NUM_MASTERS < 2 || NUM_MASTERS > 8) begin : g_bad_mst
      $error("NUM_MASTERS must be 2 to 8");
   end
   if (NUM_PORTS < 1 || NUM_PORTS > 8) begin : g_bad_port
      $error("NUM_PORTS must be 1 to 8");
   end
   if (ADDR_W > DATA_W || ACC_W > DATA_W || GRAN_LSB < 1 || GRAN_LSB >= ADDR_W) begin : g_bad_w
      $error("address, rights or page width does not fit the data word");
   end

   logic                              glb_en;
   logic [NUM_REGIONS-1:0][RA_W-1:0]  rgn_lo;
   logic [NUM_REGIONS-1:0][RA_W-1:0]  rgn_hi;
   logic [NUM_REGIONS-1:0][ACC_W-1:0] rgn_acc;
   logic [NUM_REGIONS-1:0]            rgn_vld;
   logic [NUM_PORTS-1:0]              deny_now;

   mpc_desc_bank #(
      .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB),
      .ACC_W(ACC_W), .DATA_W(DATA_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .glb_en(glb_en),
      .rgn_lo(rgn_lo), .rgn_hi(rgn_hi), .rgn_acc(rgn_acc), .rgn_vld(rgn_vld)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      mpc_port_check #(
         .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB),
         .NUM_MASTERS(NUM_MASTERS), .ACC_W(ACC_W), .MID_W(MID_W)
      ) u_chk (
         .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
         .rgn_lo(rgn_lo), .rgn_hi(rgn_hi), .rgn_acc(rgn_acc), .rgn_vld(rgn_vld),
         .req(acc_req[p]), .addr(acc_addr[p]), .mid(acc_mid[p]),
         .kind(acc_kind[p]), .sup(acc_sup[p]),
         .deny_now(deny_now[p]), .rsp_vld(rsp_vld[p]), .rsp_err(rsp_err[p])
      );

      mpc_fault_rec #(
         .ADDR_W(ADDR_W), .MID_W(MID_W), .KEEP_FIRST(KEEP_FIRST)
      ) u_flt (
         .clk(clk), .rst_n(rst_n), .cap(deny_now[p]), .clr(flt_clr[p]),
         .addr(acc_addr[p]), .mid(acc_mid[p]), .kind(acc_kind[p]),
         .flt_vld(flt_vld[p]), .flt_addr(flt_addr[p]),
         .flt_mid(flt_mid[p]), .flt_kind(flt_kind[p])
      );
   end
endmodule

// File: rtl/mpc_region_guard_sva.sv
module mpc_region_guard_sva #(
   parameter int NUM_REGIONS = 16,
   parameter int NUM_PORTS   = 2,
   parameter int ADDR_W      = 32,
   parameter int CFG_AW      = 8
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             cfg_we,
   input logic [CFG_AW-1:0]                cfg_addr,
   input logic                             glb_en,
   input logic [NUM_REGIONS-1:0]           rgn_vld,
   input logic [NUM_PORTS-1:0]             acc_req,
   input logic [NUM_PORTS-1:0]             rsp_vld,
   input logic [NUM_PORTS-1:0]             rsp_err,
   input logic [NUM_PORTS-1:0]             flt_clr,
   input logic [NUM_PORTS-1:0]             flt_vld,
   input logic [NUM_PORTS-1:0][ADDR_W-1:0] flt_addr
);
   localparam int RI_W = $clog2(NUM_REGIONS);

   logic [1:0]      sp;
   logic [RI_W-1:0] idx;
   logic [1:0]      wd;
   assign sp  = cfg_addr[CFG_AW-1 -: 2];
   assign idx = cfg_addr[RI_W+1:2];
   assign wd  = cfg_addr[1:0];

   AST_EDIT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && sp == 2'd0 && wd != 2'd3) |=> !rgn_vld[$past(idx)]); // R8
   AST_LAST_WORD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && sp == 2'd0 && wd == 2'd3) |=> rgn_vld[$past(idx)]); // R8
   AST_ALT_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && sp == 2'd1) |=> (rgn_vld == $past(rgn_vld))); // R9

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
      AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
         acc_req[p] |=> rsp_vld[p]); // R3
      AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_req[p] |=> !rsp_vld[p]); // R3
      AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_err[p] |-> rsp_vld[p]); // R3
      AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         (!glb_en && acc_req[p]) |=> !rsp_err[p]); // R2
      AST_ERR_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_err[p] |-> flt_vld[p]); // R11
      AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         (flt_vld[p] && !flt_clr[p]) |=> (flt_vld[p] && $stable(flt_addr[p]))); // R11
   end
endmodule

bind mpc_region_guard mpc_region_guard_sva #(
   .NUM_REGIONS(NUM_REGIONS), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)
) u_sva (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .glb_en(glb_en), .rgn_vld(rgn_vld), .acc_req(acc_req), .rsp_vld(rsp_vld),
   .rsp_err(rsp_err), .flt_clr(flt_clr), .flt_vld(flt_vld), .flt_addr(flt_addr)
);

// File: tb/sim_mpc_region_guard.sv
`timescale 1ns/1ps
module sim_mpc_region_guard;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [7:0]        cfg_addr = '0;
   logic [31:0]       cfg_wdata = '0;
   logic [31:0]       cfg_rdata;
   logic [1:0]        acc_req = '0;
   logic [1:0][31:0]  acc_addr = '0;
   logic [1:0][1:0]   acc_mid = '0;
   logic [1:0][1:0]   acc_kind = '0;
   logic [1:0]        acc_sup = '0;
   logic [1:0]        rsp_vld, rsp_err;
   logic [1:0]        flt_clr = '0;
   logic [1:0]        flt_vld;
   logic [1:0][31:0]  flt_addr;
   logic [1:0][1:0]   flt_mid, flt_kind;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   mpc_region_guard u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_req(acc_req),
      .acc_addr(acc_addr), .acc_mid(acc_mid), .acc_kind(acc_kind),
      .acc_sup(acc_sup), .rsp_vld(rsp_vld), .rsp_err(rsp_err),
      .flt_clr(flt_clr), .flt_vld(flt_vld), .flt_addr(flt_addr),
      .flt_mid(flt_mid), .flt_kind(flt_kind)
   );

   // reference model
   logic [26:0] m_lo [16];
   logic [26:0] m_hi [16];
   logic [9:0]  m_acc[16];
   bit          m_vld[16];
   bit          m_en;
   bit          mf_vld[2];
   logic [31:0] mf_addr[2];
   logic [1:0]  mf_mid[2];
   logic [1:0]  mf_kind[2];

   function automatic bit permitted(input logic [31:0] a, input int mid, input int kind, input bit sup);
      int want;
      bit ok;
      want = -1;
      ok = 0;
      if (mid == 0 && kind != 3) want = (sup ? 0 : 3) + kind;
      else if (mid == 1 || mid == 2) begin
         if (kind == 0) want = 6 + 2 * (mid - 1);
         else if (kind == 1) want = 7 + 2 * (mid - 1);
      end
      for (int r = 0; r < 16; r++)
         if (want >= 0 && m_vld[r] && a[31:5] >= m_lo[r] && a[31:5] <= m_hi[r] && m_acc[r][want[3:0]])
            ok = 1;
      return ok;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic raw_wr(input logic [7:0] a, input logic [31:0] d);
      cfg_we = 1'b1;
      cfg_addr = a;
      cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic wr_desc(input logic [3:0] r, input logic [1:0] w, input logic [31:0] d);
      case (w)
         2'd0: m_lo[r] = d[31:5];
         2'd1: m_hi[r] = d[31:5];
         2'd2: m_acc[r] = d[9:0];
         default: ;
      endcase
      m_vld[r] = (w == 2'd3);
      raw_wr({2'b00, r, w}, d);
   endtask

   task automatic wr_alt(input logic [3:0] r, input logic [31:0] d);
      m_acc[r] = d[9:0];
      raw_wr({2'b01, r, 2'b00}, d);
   endtask

   task automatic wr_ctrl(input bit en);
      m_en = en;
      raw_wr(8'h80, {31'b0, en});
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      cfg_addr = a;
      #1;
      check(tag, {32'b0, cfg_rdata}, {32'b0, exp});
   endtask

   task automatic region(input logic [3:0] r, input logic [31:0] lo, input logic [31:0] hi, input logic [9:0] acc);
      wr_desc(r, 2'd0, lo);
      wr_desc(r, 2'd1, hi);
      wr_desc(r, 2'd2, {22'b0, acc});
      wr_desc(r, 2'd3, 32'd1);
   endtask

   task automatic set_port(input int p, input logic [31:0] a, input logic [1:0] mid, input logic [1:0] kind, input bit sup);
      acc_req[p] = 1'b1;
      acc_addr[p] = a;
      acc_mid[p] = mid;
      acc_kind[p] = kind;
      acc_sup[p] = sup;
   endtask

   // apply the staged requests for one cycle, then check verdict and fault records
   task automatic fire(input string tag);
      bit e[2];
      for (int p = 0; p < 2; p++)
         e[p] = acc_req[p] && m_en && !permitted(acc_addr[p], int'(acc_mid[p]), int'(acc_kind[p]), acc_sup[p]);
      tick();
      for (int p = 0; p < 2; p++) begin
         check({tag, " R3 rsp_vld"}, {63'b0, rsp_vld[p]}, {63'b0, acc_req[p]});
         check({tag, " R7 rsp_err"}, {63'b0, rsp_err[p]}, {63'b0, e[p]});
         if (e[p] && (!mf_vld[p] || flt_clr[p])) begin
            mf_vld[p] = 1;
            mf_addr[p] = acc_addr[p];
            mf_mid[p] = acc_mid[p];
            mf_kind[p] = acc_kind[p];
         end else if (flt_clr[p]) mf_vld[p] = 0;
         check({tag, " R11 flt_vld"}, {63'b0, flt_vld[p]}, {63'b0, mf_vld[p]});
         if (mf_vld[p])
            check({tag, " R11 flt_rec"}, {28'b0, flt_addr[p], flt_mid[p], flt_kind[p]},
                  {28'b0, mf_addr[p], mf_mid[p], mf_kind[p]});
      end
      acc_req = '0;
      flt_clr = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < 16; r++) begin
         m_lo[r] = '0; m_hi[r] = '0; m_acc[r] = '0; m_vld[r] = 0;
      end
      m_en = 0;
      for (int p = 0; p < 2; p++) begin
         mf_vld[p] = 0; mf_addr[p] = '0; mf_mid[p] = '0; mf_kind[p] = '0;
      end
      void'($urandom(32'd7351));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 rsp_vld", {62'b0, rsp_vld}, 64'd0);
      check("R1 flt_vld", {62'b0, flt_vld}, 64'd0);
      rd_chk(8'h80, 32'd0, "R1 enable");
      rd_chk({2'b00, 4'd7, 2'd3}, 32'd0, "R1 valid");

      // R2 disabled: even impossible accesses pass
      set_port(0, 32'h0000_1234, 2'd3, 2'd3, 1'b0);
      set_port(1, 32'hFFFF_FFE0, 2'd1, 2'd2, 1'b0);
      fire("R2 disabled");

      // R4 R8 R12 programming and read-back
      wr_desc(4'd0, 2'd0, 32'h0000_100F);
      rd_chk({2'b00, 4'd0, 2'd3}, 32'd0, "R8 start write retires");
      rd_chk({2'b00, 4'd0, 2'd0}, 32'h0000_1000, "R4 start low bits zero");
      wr_desc(4'd0, 2'd1, 32'h0000_1FE0);
      rd_chk({2'b00, 4'd0, 2'd1}, 32'h0000_1FFF, "R4 end low bits ones");
      wr_desc(4'd0, 2'd2, 32'h0000_0007);
      rd_chk({2'b00, 4'd0, 2'd2}, 32'h0000_0007, "R12 rights word");
      wr_desc(4'd0, 2'd3, 32'd1);
      rd_chk({2'b00, 4'd0, 2'd3}, 32'd1, "R8 last word arms");
      wr_ctrl(1'b1);
      rd_chk(8'h80, 32'd1, "R12 control");

      // R4 R7 R10 boundaries, both ports in the same cycle
      set_port(0, 32'h0000_1000, 2'd0, 2'd0, 1'b1);
      set_port(1, 32'h0000_0FFF, 2'd0, 2'd0, 1'b1);
      fire("R4 low edge");
      set_port(0, 32'h0000_2000, 2'd0, 2'd1, 1'b1);
      set_port(1, 32'h0000_1FFF, 2'd0, 2'd1, 1'b1);
      fire("R4 high edge");
      flt_clr = 2'b11;
      fire("R11 clear");

      // R5 rights selection
      set_port(0, 32'h0000_1000, 2'd0, 2'd0, 1'b0);
      set_port(1, 32'h0000_1040, 2'd1, 2'd0, 1'b0);
      fire("R5 user and master1 denied");
      flt_clr = 2'b11;
      fire("R11 clear");

      // R6 overlap
      region(4'd1, 32'h0000_1800, 32'h0000_27FF, 10'h0C8);
      set_port(0, 32'h0000_1900, 2'd0, 2'd0, 1'b0);
      set_port(1, 32'h0000_1900, 2'd0, 2'd2, 1'b1);
      fire("R6 overlap grants");
      set_port(0, 32'h0000_2700, 2'd1, 2'd1, 1'b0);
      set_port(1, 32'h0000_2700, 2'd2, 2'd0, 1'b0);
      fire("R5 master1 write, master2 read");
      set_port(0, 32'h0000_1900, 2'd1, 2'd2, 1'b1);
      set_port(1, 32'h0000_1900, 2'd0, 2'd3, 1'b1);
      fire("R5 exec by master1, kind 3");
      // R11 second error while held, then clear with simultaneous error
      set_port(0, 32'h0000_5000, 2'd3, 2'd0, 1'b1);
      fire("R11 hold first");
      flt_clr = 2'b01;
      set_port(0, 32'h0000_6000, 2'd2, 2'd1, 1'b0);
      fire("R11 clear with capture");
      flt_clr = 2'b11;
      fire("R11 clear");

      // R9 alternate rights
      wr_alt(4'd1, 32'h0000_0300);
      rd_chk({2'b00, 4'd1, 2'd3}, 32'd1, "R9 valid kept");
      rd_chk({2'b01, 4'd1, 2'd0}, 32'h0000_0300, "R9 alt readback");
      set_port(0, 32'h0000_2700, 2'd2, 2'd0, 1'b0);
      set_port(1, 32'h0000_2700, 2'd1, 2'd1, 1'b0);
      fire("R9 new rights");
      wr_desc(4'd1, 2'd2, 32'h0000_0300);
      rd_chk({2'b00, 4'd1, 2'd3}, 32'd0, "R8 rights write retires");
      flt_clr = 2'b11;
      set_port(0, 32'h0000_2700, 2'd2, 2'd0, 1'b0);
      fire("R8 retired region");

      // random regions and accesses
      for (int k = 0; k < 6; k++) begin
         logic [8:0] a, b;
         a = 9'($urandom_range(0, 511));
         b = 9'($urandom_range(0, 511));
         if (a > b) begin logic [8:0] t; t = a; a = b; b = t; end
         region(4'(2 + k), {18'b0, a, 5'b0}, {18'b0, b, 5'h1F}, 10'($urandom));
      end
      for (int n = 0; n < 400; n++) begin
         for (int p = 0; p < 2; p++)
            if ($urandom_range(0, 3) != 0)
               set_port(p, 32'($urandom_range(0, 16383)), 2'($urandom), 2'($urandom), 1'($urandom));
         flt_clr = 2'($urandom_range(0, 7) == 0 ? 3 : 0);
         if (n == 300) wr_ctrl(1'b0);
         fire(n < 300 ? "R6 R10 random" : "R2 random disabled");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule